// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

A per-processor timer that raises an interrupt request carrying a programmed vector. Software programs it through a small word-addressed register window: a control entry (vector, mask, mode), an initial count, a read-only live count and a divide selector. In the two counting modes the live count steps down once per divided clock tick. One-shot mode raises the request once and stays idle. Periodic mode raises it and reloads on every expiry.

A third mode compares a 64-bit timestamp input against a deadline value. The deadline is loaded through its own write port, and only while the timer is in that mode. When the timestamp reaches the deadline the request fires once and the deadline clears. A masked timer keeps counting but never drives its request. Delivery and prioritisation of the request are left to the surrounding logic; the block only presents a one-cycle valid pulse and the vector.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control entry reads 0x0001_0000 (vector 0, mask set, one-shot mode), the initial count, live count and divide selector read 0, and no request is raised.
- R2: Register offsets are 0x320 control, 0x380 initial count, 0x390 live count and 0x3E0 divide selector. The control entry holds the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17; other control bits read 0. The divide selector keeps bits 3:0. Writes to the live count and reads of any other offset return 0.
- R3: The divide factor is taken from selector bits {3,1,0} with bit 2 ignored: 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128, 0xB→1.
- R4: Mode 00 is one-shot, and the reserved mode 11 behaves the same way. A write of N to the initial count at clock edge E0 loads the live count with N and restarts the divider. With divide factor d the live count drops by one at edges E0+d, E0+2d, and so on. irq_valid is high for exactly the one cycle after edge E0+N*d, and the live count then stays 0.
- R5: Mode 01 is periodic. The request fires after every N*d cycles, and the live count reloads from the initial count at each expiry.
- R6: Writing zero to the initial count stops the timer. The live count reads 0 and no request follows.
- R7: With the mask bit set the count still runs down but irq_valid stays low. Whenever irq_valid is high, irq_vector equals the control entry's vector field.
- R8: Mode 10 is deadline mode. If the deadline is nonzero and the timestamp input is greater than or equal to it at edge E, irq_valid is high for the one cycle after E. The deadline then clears, so the request does not fire again.
- R9: A deadline write is ignored unless the control entry is already in deadline mode. Writing a zero deadline disarms the comparison.
- R10: The live count register returns the current count value at any time.
- R11: In deadline mode the live count is loaded by initial-count writes but does not step down. Writing the control entry to leave deadline mode clears the deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dl_wr | input | 1 | Deadline write strobe |
| dl_wdata | input | 64 | Deadline value |
| tsc | input | 64 | Free-running timestamp to compare against the deadline |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
Register writes take effect at the edge that samples them, and reads are combinational, so each read is checked in the cycle after the write. The counting request is due in the cycle after edge E0+N*d, where E0 is the edge that took the initial-count write. Each check that follows a write waits that exact number of clock edges from the write, sampling at the falling edge. The checks also look one cycle before and one cycle after, to confirm the pulse is exactly one cycle wide. A deadline match sampled at an edge shows on irq_valid in the next cycle, and the bench samples there and for several cycles afterwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h320;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 12'h380;
  localparam logic [ADDR_W-1:0] OFS_LIVE  = 12'h390;
  localparam logic [ADDR_W-1:0] OFS_DIVSEL = 12'h3E0;

  localparam logic [1:0] MODE_ONESHOT  = 2'b00;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;
  localparam logic [1:0] MODE_DEADLINE = 2'b10;

  // Selector bits {3,1,0} form an index; index 7 means divide by 1,
  // every other index i means divide by 2^(i+1). Bit 2 plays no part.
  function automatic logic [2:0] div_shift(input logic [3:0] sel);
    logic [2:0] idx;
    idx = {sel[3], sel[1], sel[0]};
    return (idx == 3'd7) ? 3'd0 : idx + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int MAX_SHIFT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [3:0] div_sel,
  output logic       tick
);
  localparam int PRE_W = MAX_SHIFT;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'((1 << tmr_pkg::div_shift(div_sel)) - 1);
    tick  = (pre_cnt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pre_cnt <= '0;
    else if (restart || tick) pre_cnt <= '0;
    else                    pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_val,
  input  logic             tick,
  input  logic             run,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             fire
);
  logic step;

  assign step = run && tick && (cur != '0) && !load;
  assign fire = step && (cur == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur <= '0;
    else if (load)  cur <= load_val;
    else if (fire)  cur <= periodic ? init_val : '0;
    else if (step)  cur <= cur - 1'b1;
  end
endmodule

// File: rtl/tmr_deadline.sv
module tmr_deadline #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [TS_W-1:0] wdata,
  input  logic            in_mode,
  input  logic            leave,
  input  logic [TS_W-1:0] tsc,
  output logic [TS_W-1:0] deadline,
  output logic            fire
);
  logic accept;

  assign accept = wr && in_mode;
  assign fire   = in_mode && (deadline != '0) && (tsc >= deadline) && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              deadline <= '0;
    else if (accept)         deadline <= wdata;
    else if (leave || fire)  deadline <= '0;
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W     = 32,
  parameter int TS_W      = 64,
  parameter int VEC_W     = 8,
  parameter int MAX_SHIFT = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [tmr_pkg::ADDR_W-1:0] reg_addr,
  input  logic [tmr_pkg::DATA_W-1:0] reg_wdata,
  output logic [tmr_pkg::DATA_W-1:0] reg_rdata,
  input  logic                      dl_wr,
  input  logic [TS_W-1:0]           dl_wdata,
  input  logic [TS_W-1:0]           tsc,
  output logic                      irq_valid,
  output logic [VEC_W-1:0]          irq_vector
);
  import tmr_pkg::*;

  localparam int MASK_BIT = 16;
  localparam int MODE_LO  = 17;

  logic [VEC_W-1:0] ctl_vec;
  logic             ctl_mask;
  logic [1:0]       ctl_mode;
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;
  logic             fire_q;

  // Named events, visible to the bound checker.
  logic ctl_wr, init_wr, div_wr, leave_dl, tick, cnt_fire, dl_fire, in_dl;
  logic [1:0]       new_mode;
  logic [CNT_W-1:0] cur;
  logic [TS_W-1:0]  deadline;

  assign ctl_wr   = reg_wr && (reg_addr == OFS_CTRL);
  assign init_wr  = reg_wr && (reg_addr == OFS_INIT);
  assign div_wr   = reg_wr && (reg_addr == OFS_DIVSEL);
  assign new_mode = reg_wdata[MODE_LO+1:MODE_LO];
  assign in_dl    = (ctl_mode == MODE_DEADLINE);
  assign leave_dl = ctl_wr && in_dl && (new_mode != MODE_DEADLINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_vec  <= '0;
      ctl_mask <= 1'b1;
      ctl_mode <= MODE_ONESHOT;
      init_q   <= '0;
      div_q    <= '0;
      fire_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_vec  <= reg_wdata[VEC_W-1:0];
        ctl_mask <= reg_wdata[MASK_BIT];
        ctl_mode <= new_mode;
      end
      if (init_wr) init_q <= reg_wdata[CNT_W-1:0];
      if (div_wr)  div_q  <= reg_wdata[3:0];
      fire_q <= cnt_fire || dl_fire;
    end
  end

  tmr_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(init_wr || div_wr),
    .div_sel(div_q), .tick(tick)
  );

  tmr_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(init_wr),
    .load_val(reg_wdata[CNT_W-1:0]), .init_val(init_q), .tick(tick),
    .run(!in_dl), .periodic(ctl_mode == MODE_PERIODIC),
    .cur(cur), .fire(cnt_fire)
  );

  tmr_deadline #(.TS_W(TS_W)) u_dl (
    .clk(clk), .rst_n(rst_n), .wr(dl_wr), .wdata(dl_wdata),
    .in_mode(in_dl), .leave(leave_dl), .tsc(tsc),
    .deadline(deadline), .fire(dl_fire)
  );

  function automatic logic [DATA_W-1:0] read_mux(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r;
    r = '0;
    case (a)
      OFS_CTRL: begin
        r[VEC_W-1:0]         = ctl_vec;
        r[MASK_BIT]          = ctl_mask;
        r[MODE_LO+1:MODE_LO] = ctl_mode;
      end
      OFS_INIT:   r[CNT_W-1:0] = init_q;
      OFS_LIVE:   r[CNT_W-1:0] = cur;
      OFS_DIVSEL: r[3:0]       = div_q;
      default:    r = '0;
    endcase
    return r;
  endfunction

  assign reg_rdata  = read_mux(reg_addr);
  assign irq_valid  = fire_q && !ctl_mask;
  assign irq_vector = ctl_vec;
endmodule

// File: rtl/irq_countdown_timer_chk.sv
module irq_countdown_timer_chk #(
  parameter int CNT_W = 32,
  parameter int TS_W  = 64,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_wr,
  input logic [31:0]      reg_wdata,
  input logic             dl_wr,
  input logic [1:0]       ctl_mode,
  input logic             ctl_mask,
  input logic [CNT_W-1:0] cur,
  input logic [CNT_W-1:0] init_q,
  input logic [TS_W-1:0]  deadline,
  input logic             dl_fire,
  input logic             irq_valid
);
  // R7: a masked entry never drives the request
  p_mask_silences_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mask |-> !irq_valid);

  // R4: an initial-count write loads the live count with the written value
  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (cur == $past(reg_wdata[CNT_W-1:0])));

  // R4: one-shot holds at zero until a new load
  p_oneshot_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'b00 && cur == '0 && !init_wr) |=> (cur == '0));

  // R5: the live count never rises above the initial count
  p_cur_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur <= init_q));

  // R9: a deadline write outside deadline mode leaves the deadline as it was
  p_dl_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_wr && ctl_mode != 2'b10) |=> $stable(deadline));

  // R8: a deadline match clears the deadline
  p_dl_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_fire && !dl_wr) |=> (deadline == '0));

  // R11: no stepping of the live count in deadline mode
  p_dl_no_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mode == 2'b10 && !init_wr) |=> $stable(cur));
endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(
  .CNT_W(CNT_W), .TS_W(TS_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .reg_wdata(reg_wdata),
  .dl_wr(dl_wr), .ctl_mode(ctl_mode), .ctl_mask(ctl_mask), .cur(cur),
  .init_q(init_q), .deadline(deadline), .dl_fire(dl_fire),
  .irq_valid(irq_valid)
);

// File: tb/tb_irq_countdown_timer.sv
`timescale 1ns/1ps
module tb_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dl_wr = 1'b0;
  logic [63:0] dl_wdata = '0;
  logic [63:0] tsc = '0;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [11:0] A_CTL = 12'h320, A_INIT = 12'h380,
                          A_LIVE = 12'h390, A_DIV = 12'h3E0;

  always #2.5 clk = ~clk;

  irq_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dl_wr(dl_wr),
    .dl_wdata(dl_wdata), .tsc(tsc), .irq_valid(irq_valid),
    .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_dl(input logic [63:0] d);
    dl_wr = 1'b1; dl_wdata = d;
    @(posedge clk); @(negedge clk);
    dl_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // Divide factor restated as a lookup on the full selector.
  function automatic int factor_of(input logic [3:0] s);
    case (s & 4'hB)
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;   4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128; default: return 1;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_CTL, d);  check("R1 ctl", d, 32'h0001_0000);
    rd_reg(A_INIT, d); check("R1 init", d, 0);
    rd_reg(A_LIVE, d); check("R1 live", d, 0);
    rd_reg(A_DIV, d);  check("R1 div", d, 0);
    check("R1 irq", irq_valid, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr_reg(A_CTL, 32'h0005_0023);
    rd_reg(A_CTL, d); check("R2 ctl fields", d, 32'h0005_0023);
    wr_reg(A_CTL, 32'hFFFF_FFFF);
    rd_reg(A_CTL, d); check("R2 ctl unused bits", d, 32'h0007_00FF);
    wr_reg(A_DIV, 32'h0000_00FF);
    rd_reg(A_DIV, d); check("R2 div width", d, 32'hF);
    wr_reg(A_LIVE, 32'h1234);
    rd_reg(A_LIVE, d); check("R2 live not writable", d, 0);
    rd_reg(12'h200, d); check("R2 unmapped", d, 0);
    wr_reg(A_CTL, 32'h0001_0000);
  endtask

  // One-shot with N and selector; checks the single pulse at N*d.
  task automatic t_oneshot(input int n, input logic [3:0] sel, input string req);
    int k;
    logic [31:0] d;
    k = n * factor_of(sel);
    wr_reg(A_CTL, 32'h0000_0040);
    wr_reg(A_DIV, {28'h0, sel});
    wr_reg(A_INIT, n);
    rd_reg(A_LIVE, d); check({req, " R10 live after load"}, d, n);
    if (k > 1) begin
      wait_cyc(k - 1); check({req, " R4 no early irq"}, irq_valid, 0);
    end
    wait_cyc(1);
    check({req, " R4 irq at N*d"}, irq_valid, 1);
    check({req, " R7 vector"}, irq_vector, 8'h40);
    wait_cyc(1); check({req, " R4 one cycle"}, irq_valid, 0);
    wait_cyc(3);
    rd_reg(A_LIVE, d); check({req, " R4 stays zero"}, d, 0);
    check({req, " R4 no refire"}, irq_valid, 0);
  endtask

  task automatic t_live_midway();
    logic [31:0] d;
    wr_reg(A_CTL, 32'h0000_0040);
    wr_reg(A_DIV, 32'h1);
    wr_reg(A_INIT, 2);
    wait_cyc(4);
    rd_reg(A_LIVE, d); check("R10 live after one tick", d, 1);
    check("R4 quiet mid count", irq_valid, 0);
    wait_cyc(4);
    check("R4 irq at 8", irq_valid, 1);
    wait_cyc(1);
  endtask

  task automatic t_periodic();
    int bad = 0;
    logic [31:0] d;
    wr_reg(A_CTL, 32'h0002_0041);
    wr_reg(A_DIV, 32'h0);
    wr_reg(A_INIT, 3);
    for (int k = 1; k <= 19; k++) begin
      wait_cyc(1);
      if (irq_valid !== ((k % 6) == 0)) bad++;
    end
    check("R5 periodic pulses every 6", bad, 0);
    rd_reg(A_LIVE, d); check("R5 reloaded count", d, 3);
    wr_reg(A_INIT, 0);
  endtask

  task automatic t_mask();
    int hits = 0;
    logic [31:0] d;
    wr_reg(A_CTL, 32'h0001_0040);
    wr_reg(A_DIV, 32'hB);
    wr_reg(A_INIT, 2);
    for (int k = 1; k <= 5; k++) begin
      wait_cyc(1);
      if (irq_valid) hits++;
    end
    check("R7 masked silent", hits, 0);
    rd_reg(A_LIVE, d); check("R7 masked still counts", d, 0);
  endtask

  task automatic t_stop();
    int hits = 0;
    logic [31:0] d;
    wr_reg(A_CTL, 32'h0000_0040);
    wr_reg(A_DIV, 32'hB);
    wr_reg(A_INIT, 10);
    wait_cyc(3);
    wr_reg(A_INIT, 0);
    rd_reg(A_LIVE, d); check("R6 stop clears live", d, 0);
    for (int k = 1; k <= 15; k++) begin
      wait_cyc(1);
      if (irq_valid) hits++;
    end
    check("R6 no irq after stop", hits, 0);
  endtask

  task automatic t_deadline();
    int hits = 0;
    logic [31:0] d;
    tsc = 0;
    wr_reg(A_CTL, 32'h0000_0055);
    wr_dl(64'd50);
    tsc = 64'd1000;
    wr_reg(A_CTL, 32'h0004_0055);
    for (int k = 1; k <= 5; k++) begin wait_cyc(1); if (irq_valid) hits++; end
    check("R9 write outside mode ignored", hits, 0);

    tsc = 0;
    wr_dl(64'd100);
    wait_cyc(3); check("R8 not yet", irq_valid, 0);
    tsc = 64'd100;
    wait_cyc(1);
    check("R8 fires at equal", irq_valid, 1);
    check("R8 vector", irq_vector, 8'h55);
    tsc = 64'd200;
    wait_cyc(1); check("R8 one cycle", irq_valid, 0);
    hits = 0;
    for (int k = 1; k <= 5; k++) begin wait_cyc(1); if (irq_valid) hits++; end
    check("R8 cleared after fire", hits, 0);

    wr_dl(64'd0);
    hits = 0;
    for (int k = 1; k <= 4; k++) begin wait_cyc(1); if (irq_valid) hits++; end
    check("R9 zero disarms", hits, 0);

    wr_reg(A_INIT, 5);
    wait_cyc(10);
    rd_reg(A_LIVE, d); check("R11 count held in deadline mode", d, 5);
    wr_reg(A_INIT, 0);
    tsc = 0;
    wr_dl(64'd500);
    wr_reg(A_CTL, 32'h0000_0055);
    wr_reg(A_CTL, 32'h0004_0055);
    tsc = 64'd1000;
    hits = 0;
    for (int k = 1; k <= 4; k++) begin wait_cyc(1); if (irq_valid) hits++; end
    check("R11 leaving mode disarms", hits, 0);
    wr_reg(A_CTL, 32'h0001_0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regmap();
    t_oneshot(3, 4'hB, "R3 div1");
    t_oneshot(2, 4'h1, "R3 div4");
    t_oneshot(1, 4'hA, "R3 div128");
    t_oneshot(2, 4'hF, "R3 bit2 ignored");
    t_oneshot(1, 4'h9, "R3 div64");
    t_live_midway();
    t_periodic();
    t_mask();
    t_stop();
    t_deadline();
    finish_run();
  end
endmodule